// File: doc/BRIEF.md
# Add/Compare Unit Keeping Its Carry in the Program Counter

This block adds, subtracts, compares and selects minimum or maximum values on a 16-bit datapath (the width is a parameter). It has no status register. The carry/borrow flag is stored in bit 0 of the program counter instead. Instructions are always aligned to 2-byte boundaries, so that bit is never used as part of an address.

The unit owns the program counter register. Every cycle, other units may write a new program counter value. Such a write only changes bits 15..1. Bit 0 changes only when this unit executes an operation.

Results appear combinationally, in the same cycle as the operands:
- `res_o` carries the result.
- `wb_en_o` is the writeback enable.
- `carry_next_o` is the carry being produced.

The program counter, with its new carry in bit 0, is updated on the next clock edge. Other logic can read the carry as `pc_o[0]`.

Top module: `asu_pc_carry`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pc_o` equals the parameter RESET_PC, whose bit 0 is 0. `wb_en_o` is 0 whenever `op_valid` is 0.
- R2: Opcode 0 (ADD) gives `res_o` = (A+B) mod 2^16. It sets `wb_en_o`. The carry is the unsigned carry out of bit 15.
- R3: Opcode 1 (SUB) gives `res_o` = (A-B) mod 2^16. It sets `wb_en_o`. The carry is 1 exactly when A >= B as unsigned values (no borrow).
- R4: Opcodes 2 (CMPU) and 3 (CMPS) hold `wb_en_o` at 0. Their carry is 1 exactly when A > B: unsigned for CMPU, two's-complement signed for CMPS. So comparing a value with itself clears the carry, and CMPU of 0xFFFF with any other value sets it.
- R5: Opcodes 4 (MIN) and 5 (MAX) set `wb_en_o`. They write the unsigned smaller or larger operand. The carry is the unsigned A > B result.
- R6: Opcodes 6 (SMIN) and 7 (SMAX) set `wb_en_o`. They write the signed smaller or larger operand. The carry is the signed A > B result.
- R7: When `pc_wr_en` is 1, bits 15..1 of `pc_o` take `pc_wr_val[15:1]` at the next edge. `pc_wr_val[0]` is ignored.
- R8: When `op_valid` is 1, `pc_o[0]` takes `carry_next_o` at the next edge. Bits 15..1 of `pc_o` hold their value unless `pc_wr_en` is 1.
- R9: An operation and a program counter write in the same cycle both take effect at the same edge. The upper bits come from the write and bit 0 comes from the operation.
- R10: When `op_valid` is 0, `pc_o[0]` holds its value and `carry_next_o` equals `pc_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_sel | input | 3 | Opcode, 0..7 = ADD, SUB, CMPU, CMPS, MIN, MAX, SMIN, SMAX |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| pc_wr_en | input | 1 | Another unit writes the program counter |
| pc_wr_val | input | 16 | Program counter value from that unit (bit 0 ignored) |
| res_o | output | 16 | Operation result |
| wb_en_o | output | 1 | Writeback enable for `res_o` |
| carry_next_o | output | 1 | Carry produced this cycle |
| pc_o | output | 16 | Program counter; bit 0 is the carry |

## Verification
The key collision is a carry-producing operation and an external program counter write landing on the same clock edge. The register must then merge bits 15..1 from the write with bit 0 from the operation.

The bench provokes this collision two ways:
- Directed cases pair a write whose bit 0 disagrees with the new carry.
- A long random run makes both inputs active together often.

One cycle later, the bench judges the result by comparing all of `pc_o` against a behavioural model that holds the upper bits and the carry as separate integers.

// File: rtl/asu_pkg.sv
package asu_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_CMPU = 3'd2,
      OP_CMPS = 3'd3,
      OP_MIN  = 3'd4,
      OP_MAX  = 3'd5,
      OP_SMIN = 3'd6,
      OP_SMAX = 3'd7
   } asu_op_e;
endpackage

// File: rtl/asu_addsub.sv
module asu_addsub #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int EXT = WIDTH + 1;
   logic [EXT-1:0] total;
   logic [WIDTH-1:0] b_eff;

   always_comb begin
      b_eff = sub ? ~b : b;
      total = {1'b0, a} + {1'b0, b_eff} + {{(EXT-1){1'b0}}, sub};
      sum   = total[WIDTH-1:0];
      cout  = total[EXT-1];
   end
endmodule

// File: rtl/asu_cmp.sv
module asu_cmp #(
   parameter int WIDTH = 16,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             gt_u,
   output logic             gt_s
);
   localparam int MSB = WIDTH - 1;

   generate
      if (STYLE == 0) begin : g_subtract
         logic [WIDTH:0]   diff;
         logic             ovf;
         always_comb begin
            diff = {1'b0, b} - {1'b0, a};
            ovf  = (b[MSB] != a[MSB]) && (diff[MSB] != b[MSB]);
            gt_u = diff[WIDTH];
            gt_s = diff[MSB] ^ ovf;
         end
      end else begin : g_relational
         always_comb begin
            gt_u = a > b;
            gt_s = $signed(a) > $signed(b);
         end
      end
   endgenerate
endmodule

// File: rtl/asu_pcreg.sv
module asu_pcreg #(
   parameter int              WIDTH    = 16,
   parameter logic [WIDTH-1:0] RESET_PC = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_val,
   input  logic             carry_en,
   input  logic             carry_val,
   output logic [WIDTH-1:0] pc_q
);
   logic [WIDTH-2:0] addr_q;
   logic             carry_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= RESET_PC[WIDTH-1:1];
      end else if (wr_en) begin
         addr_q <= wr_val[WIDTH-1:1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q <= RESET_PC[0];
      end else if (carry_en) begin
         carry_q <= carry_val;
      end
   end

   assign pc_q = {addr_q, carry_q};
endmodule

// File: rtl/asu_pc_carry.sv
module asu_pc_carry #(
   parameter int               WIDTH     = 16,
   parameter int               CMP_STYLE = 0,
   parameter logic [WIDTH-1:0] RESET_PC  = 16'h0100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             pc_wr_en,
   input  logic [WIDTH-1:0] pc_wr_val,
   output logic [WIDTH-1:0] res_o,
   output logic             wb_en_o,
   output logic             carry_next_o,
   output logic [WIDTH-1:0] pc_o
);
   import asu_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("asu_pc_carry: WIDTH must be at least 2");
      end
      if (RESET_PC[0] != 1'b0) begin : g_bad_reset
         $error("asu_pc_carry: RESET_PC must be even");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_style
         $error("asu_pc_carry: CMP_STYLE must be 0 or 1");
      end
   endgenerate

   asu_op_e          op;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             gt_u;
   logic             gt_s;
   logic             op_carry;

   assign op = asu_op_e'(op_sel);

   asu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a    (opa),
      .b    (opb),
      .sub  (op != OP_ADD),
      .sum  (sum),
      .cout (cout)
   );

   asu_cmp #(.WIDTH(WIDTH), .STYLE(CMP_STYLE)) u_cmp (
      .a    (opa),
      .b    (opb),
      .gt_u (gt_u),
      .gt_s (gt_s)
   );

   always_comb begin
      res_o    = sum;
      wb_en_o  = 1'b0;
      op_carry = cout;
      unique case (op)
         OP_ADD, OP_SUB: begin
            wb_en_o  = 1'b1;
            op_carry = cout;
         end
         OP_CMPU: op_carry = gt_u;
         OP_CMPS: op_carry = gt_s;
         OP_MIN: begin
            wb_en_o  = 1'b1;
            op_carry = gt_u;
            res_o    = gt_u ? opb : opa;
         end
         OP_MAX: begin
            wb_en_o  = 1'b1;
            op_carry = gt_u;
            res_o    = gt_u ? opa : opb;
         end
         OP_SMIN: begin
            wb_en_o  = 1'b1;
            op_carry = gt_s;
            res_o    = gt_s ? opb : opa;
         end
         OP_SMAX: begin
            wb_en_o  = 1'b1;
            op_carry = gt_s;
            res_o    = gt_s ? opa : opb;
         end
         default: ;
      endcase
      if (!op_valid) wb_en_o = 1'b0;
   end

   assign carry_next_o = op_valid ? op_carry : pc_o[0];

   asu_pcreg #(.WIDTH(WIDTH), .RESET_PC(RESET_PC)) u_pcreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (pc_wr_en),
      .wr_val    (pc_wr_val),
      .carry_en  (op_valid),
      .carry_val (op_carry),
      .pc_q      (pc_o)
   );
endmodule

// File: rtl/asu_pc_carry_chk.sv
module asu_pc_carry_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [2:0]       op_sel,
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             pc_wr_en,
   input logic [WIDTH-1:0] pc_wr_val,
   input logic [WIDTH-1:0] res_o,
   input logic             wb_en_o,
   input logic             carry_next_o,
   input logic [WIDTH-1:0] pc_o
);
   AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !wb_en_o); // R1
   AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_sel == 3'd2 || op_sel == 3'd3)) |-> !wb_en_o); // R4
   AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 3'd4) |-> (res_o <= opa && res_o <= opb)); // R5
   AST_SMAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 3'd7) |->
      ($signed(res_o) >= $signed(opa) && $signed(res_o) >= $signed(opb))); // R6
   AST_PC_WRITE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_en |=> pc_o[WIDTH-1:1] == $past(pc_wr_val[WIDTH-1:1])); // R7
   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_wr_en |=> $stable(pc_o[WIDTH-1:1])); // R8
   AST_CARRY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> pc_o[0] == $past(carry_next_o)); // R8
   AST_BOTH_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && pc_wr_en) |=>
      pc_o == {$past(pc_wr_val[WIDTH-1:1]), $past(carry_next_o)}); // R9
   AST_IDLE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> pc_o[0] == $past(pc_o[0])); // R10
endmodule

bind asu_pc_carry asu_pc_carry_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid     (op_valid),
   .op_sel       (op_sel),
   .opa          (opa),
   .opb          (opb),
   .pc_wr_en     (pc_wr_en),
   .pc_wr_val    (pc_wr_val),
   .res_o        (res_o),
   .wb_en_o      (wb_en_o),
   .carry_next_o (carry_next_o),
   .pc_o         (pc_o)
);

// File: tb/asu_pc_carry_tb.sv
module asu_pc_carry_tb;
   localparam logic [15:0] RST_PC = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [15:0] opa = '0;
   logic [15:0] opb = '0;
   logic        pc_wr_en = 1'b0;
   logic [15:0] pc_wr_val = '0;
   logic [15:0] res_o;
   logic        wb_en_o;
   logic        carry_next_o;
   logic [15:0] pc_o;

   int checks = 0;
   int errors = 0;
   int exp_hi;
   int exp_c;

   always #10 clk = ~clk;

   asu_pc_carry u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opa(opa), .opb(opb), .pc_wr_en(pc_wr_en), .pc_wr_val(pc_wr_val),
      .res_o(res_o), .wb_en_o(wb_en_o), .carry_next_o(carry_next_o),
      .pc_o(pc_o)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string op_tag(input int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2, 3: return "R4";
         4, 5: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic step(input bit v, input int op, input int a, input int b,
                       input bit we, input int wv);
      int  ua, ub, sa, sb, eres, ec, ewb;
      int  exp_pc;
      @(negedge clk);
      exp_pc = exp_hi * 2 + exp_c;
      check(pc_o == exp_pc[15:0], "R8", "pc before step", pc_o, exp_pc);
      op_valid = v; op_sel = op[2:0]; opa = a[15:0]; opb = b[15:0];
      pc_wr_en = we; pc_wr_val = wv[15:0];
      #2;
      ua = a & 16'hFFFF; ub = b & 16'hFFFF;
      sa = (ua >= 32768) ? ua - 65536 : ua;
      sb = (ub >= 32768) ? ub - 65536 : ub;
      eres = 0; ec = exp_c; ewb = 0;
      if (v) begin
         case (op)
            0: begin eres = (ua + ub) % 65536; ec = (ua + ub > 65535); ewb = 1; end
            1: begin eres = (ua - ub + 65536) % 65536; ec = (ua >= ub); ewb = 1; end
            2: ec = (ua > ub);
            3: ec = (sa > sb);
            4: begin ec = (ua > ub); eres = ec ? ub : ua; ewb = 1; end
            5: begin ec = (ua > ub); eres = ec ? ua : ub; ewb = 1; end
            6: begin ec = (sa > sb); eres = ec ? ub : ua; ewb = 1; end
            default: begin ec = (sa > sb); eres = ec ? ua : ub; ewb = 1; end
         endcase
         check(wb_en_o == ewb[0], op_tag(op), "wb_en", wb_en_o, ewb);
         if (ewb == 1)
            check(res_o == eres[15:0], op_tag(op), "result", res_o, eres);
         check(carry_next_o == ec[0], op_tag(op), "carry", carry_next_o, ec);
      end else begin
         check(wb_en_o == 1'b0, "R1", "wb_en idle", wb_en_o, 0);
         check(carry_next_o == exp_c[0], "R10", "carry idle", carry_next_o, exp_c);
      end
      if (we) exp_hi = (wv & 16'hFFFF) / 2;
      exp_c = ec;
      if (v && we) begin
         @(negedge clk);
         exp_pc = exp_hi * 2 + exp_c;
         check(pc_o == exp_pc[15:0], "R9", "merged pc", pc_o, exp_pc);
         op_valid = 1'b0; pc_wr_en = 1'b0;
         #2;
      end
   endtask

   initial begin
      #(20 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      exp_hi = RST_PC / 2;
      exp_c  = 0;
      repeat (3) @(negedge clk);
      check(pc_o == RST_PC, "R1", "pc in reset", pc_o, RST_PC);
      check(wb_en_o == 1'b0, "R1", "wb_en in reset", wb_en_o, 0);
      rst_n = 1'b1;
      // R1: first cycle after reset
      step(0, 0, 0, 0, 0, 0);
      // R4: self compare clears, -1 compare sets
      step(1, 2, 16'h1234, 16'h1234, 0, 0);
      step(1, 2, 16'hFFFF, 16'h0005, 0, 0);
      step(1, 3, 16'h8000, 16'h7FFF, 0, 0);
      step(1, 3, 16'h0001, 16'hFFFF, 0, 0);
      // R2: wrap with carry
      step(1, 0, 16'hFFFF, 16'h0001, 0, 0);
      step(1, 0, 16'h1000, 16'h0234, 0, 0);
      // R3: equal and borrow
      step(1, 1, 16'h0003, 16'h0003, 0, 0);
      step(1, 1, 16'h0002, 16'h0005, 0, 0);
      // R5, R6
      step(1, 4, 16'h8000, 16'h0001, 0, 0);
      step(1, 5, 16'h8000, 16'h0001, 0, 0);
      step(1, 6, 16'h8000, 16'h0001, 0, 0);
      step(1, 7, 16'h8000, 16'h0001, 0, 0);
      // R7: odd write value, bit 0 ignored
      step(0, 0, 0, 0, 1, 16'h2469);
      step(0, 0, 0, 0, 0, 0);
      // R10: idle keeps carry
      step(1, 2, 16'h0009, 16'h0001, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 16'h0300);
      // R9: write bit 0 disagrees with new carry
      step(1, 2, 16'h0009, 16'h0001, 1, 16'h4444);
      step(1, 1, 16'h0001, 16'h0009, 1, 16'h5555);
      for (int i = 0; i < 600; i++) begin
         step($urandom_range(0, 3) != 0, $urandom_range(0, 7),
              $urandom_range(0, 65535), ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(0, 65535),
              $urandom_range(0, 2) == 0, $urandom_range(0, 65535));
      end
      step(0, 0, 0, 0, 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule